// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word addresses for a multi-register load or store. A single start pulse hands it a base address, a register mask, one of four addressing orders and a writeback request. It then emits one word address per selected register on a valid/ready output stream, always in ascending register number. The lowest-numbered register sits at the lowest address in every order. After the last address has been taken, it raises a one-cycle completion pulse that carries the updated base value for writeback.

The four orders differ only in where the block of words starts relative to the base. The two increment orders place the block at or just above the base. The two decrement orders place it below the base. An empty mask finishes at once with nothing transferred. A base that is not word aligned is rejected with an error flag.

The address stream follows the usual valid/ready rules. An address counts as taken on a clock edge where `addr_valid` and `addr_ready` are both high. While `addr_valid` is high and `addr_ready` is low, the address and register index stay frozen. `addr_valid` never drops without a transfer. The consumer may hold `addr_ready` low for any number of cycles.

Top module: `blk_addr_seq`

## Requirements
- R1: After reset, `busy`, `addr_valid`, `done`, `wb_valid` and `align_err` are all low.
- R2: Mode 2'b00 (increment, address then step): the k-th transferred register (k from 0) gets address base + 4k.
- R3: Mode 2'b01 (step then increment): the k-th register gets base + 4 + 4k.
- R4: Mode 2'b10 (decrement, address then step): the k-th register gets base − 4N + 4 + 4k, where N is the number of set bits in the mask.
- R5: Mode 2'b11 (step then decrement): the k-th register gets base − 4N + 4k.
- R6: `addr_reg` gives the registers in strictly ascending bit-index order of the mask, with one beat per set bit. Consecutive beats differ by +4 in address.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_out` and `addr_reg` hold their values and `addr_valid` stays high.
- R8: `done` is high for exactly one cycle. It comes in the cycle right after the final accepted beat. At that time `wb_valid` equals the writeback request. `wb_addr` is base + 4N for modes 00/01 and base − 4N for modes 10/11.
- R9: An all-zero mask gives no address beats. `done` follows in the cycle after start, and `wb_addr` equals the base.
- R10: A base with either of bits [1:0] set gives no beats. `done` and `align_err` are high together in the cycle after start, and `wb_valid` is low.
- R11: A start pulse while `busy` is high has no effect. The running sequence continues unchanged and no extra operation follows it. Inputs other than `start` are sampled only on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| base_addr | input | 32 | Base byte address |
| reg_list | input | 16 | Register selection mask |
| mode | input | 2 | Addressing order: 00/01 increment, 10/11 decrement |
| wb_en | input | 1 | Request base writeback |
| busy | output | 1 | Operation in progress, including its done cycle |
| addr_valid | output | 1 | Address beat available |
| addr_ready | input | 1 | Consumer accepts the beat |
| addr_out | output | 32 | Word address of the current beat |
| addr_reg | output | 4 | Register index of the current beat |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback value valid (with done) |
| wb_addr | output | 32 | Updated base value |
| align_err | output | 1 | Misaligned base reported (with done) |

## Verification
The hardest situation to reach is a second start arriving in the middle of a stalled sequence, together with a stall on the final beat. The final-beat stall matters because the done timing depends on the last handshake and not on the last address presented. The bench reaches both states by sweeping every mode over several masks, bases and ready patterns. An alternating ready pattern injects a stray start pulse while the block is busy. After every start, the bench scrambles the base and mask inputs so that any late sampling of them shows up in the addresses. Bases near the top and bottom of the address space make the wrap arithmetic visible.

// File: rtl/bta_pkg.sv
package bta_pkg;

  typedef enum logic [1:0] {
    MODE_INC_POST = 2'b00,
    MODE_INC_PRE  = 2'b01,
    MODE_DEC_POST = 2'b10,
    MODE_DEC_PRE  = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } seq_state_e;

endpackage

// File: rtl/bta_popcount.sv
module bta_popcount #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/bta_span_calc.sv
module bta_span_calc
  import bta_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CW         = 5,
  parameter int WORD_BYTES = 4,
  localparam int SH = $clog2(WORD_BYTES)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CW-1:0]     count,
  input  xfer_mode_e        mode,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_addr,
  output logic              misaligned
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  assign span = ADDR_W'(count) << SH;

  always_comb begin
    unique case (mode)
      MODE_INC_POST: first_addr = base;
      MODE_INC_PRE:  first_addr = base + STEP;
      MODE_DEC_POST: first_addr = base - span + STEP;
      default:       first_addr = base - span;
    endcase
    final_addr = mode[1] ? (base - span) : (base + span);
  end

  generate
    if (SH == 0) begin : g_byte
      assign misaligned = 1'b0;
    end else begin : g_word
      assign misaligned = |base[SH-1:0];
    end
  endgenerate
endmodule

// File: rtl/bta_lowest_pick.sv
module bta_lowest_pick #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  mask,
  output logic [W-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  assign grant = mask & (~mask + W'(1));
  assign any   = |mask;

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end

  // R6: at most one register picked, and it is the reported index
  assert_onehot_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]);
endmodule

// File: rtl/blk_addr_seq.sv
module blk_addr_seq
  import bta_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = $clog2(NREG + 1),
  localparam int OFS_W = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [NREG-1:0]   reg_list,
  input  logic [1:0]        mode,
  input  logic              wb_en,
  output logic              busy,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic [IDX_W-1:0]  addr_reg,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              align_err
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_state_e        state_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic              wb_q;
  logic              err_q;

  logic [CNT_W-1:0]  list_cnt;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] final_addr;
  logic              misaligned;
  logic [NREG-1:0]   pick_grant;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic [NREG-1:0]   mask_next;

  bta_popcount #(.W(NREG)) u_count (
    .bits  (reg_list),
    .count (list_cnt)
  );

  bta_span_calc #(.ADDR_W(ADDR_W), .CW(CNT_W), .WORD_BYTES(WORD_BYTES)) u_span (
    .base       (base_addr),
    .count      (list_cnt),
    .mode       (xfer_mode_e'(mode)),
    .first_addr (first_addr),
    .final_addr (final_addr),
    .misaligned (misaligned)
  );

  bta_lowest_pick #(.W(NREG)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .mask  (mask_q),
    .grant (pick_grant),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  assign mask_next = mask_q & ~pick_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mask_q    <= '0;
      addr_q    <= '0;
      wb_addr_q <= '0;
      wb_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            err_q     <= misaligned;
            wb_q      <= wb_en && !misaligned;
            wb_addr_q <= misaligned ? base_addr : final_addr;
            mask_q    <= misaligned ? '0 : reg_list;
            addr_q    <= first_addr;
            state_q   <= (misaligned || list_cnt == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (addr_ready) begin
            mask_q <= mask_next;
            addr_q <= addr_q + STEP;
            if (mask_next == '0) state_q <= ST_DONE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          err_q   <= 1'b0;
          wb_q    <= 1'b0;
        end
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign addr_valid = (state_q == ST_RUN);
  assign addr_out   = addr_q;
  assign addr_reg   = pick_idx;
  assign done       = (state_q == ST_DONE);
  assign wb_valid   = done && wb_q;
  assign wb_addr    = wb_addr_q;
  assign align_err  = done && err_q;

  // R7: stalled beat holds steady
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out) && $stable(addr_reg)));
  // R6: accepted beat is followed by a higher register one word above, or by the end
  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready) |=>
      (!addr_valid || (addr_reg > $past(addr_reg) && addr_out == $past(addr_out) + STEP)));
  // R2: emitted addresses are word aligned
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr_out[OFS_W-1:0] == '0));
  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: no beat is offered in the completion cycle
  assert_no_beat_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);
  // R10: alignment error only at completion and never with writeback
  assert_err_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (done && !wb_valid));
  // R6: a beat is only offered while registers remain
  assert_beat_has_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> pick_any);
endmodule

// File: tb/blk_addr_seq_test.sv
module blk_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_list = '0;
  logic [1:0]  mode = '0;
  logic        wb_en = 1'b0;
  logic        busy, addr_valid, done, wb_valid, align_err;
  logic        addr_ready = 1'b0;
  logic [31:0] addr_out, wb_addr;
  logic [3:0]  addr_reg;

  int checks = 0;
  int errors = 0;
  bit finished_all = 1'b0;

  always #10 clk = ~clk;

  blk_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_list(reg_list), .mode(mode), .wb_en(wb_en), .busy(busy),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
    .addr_reg(addr_reg), .done(done), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .align_err(align_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int kth_index(input logic [15:0] lst, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        if (seen == k) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic run_op(input logic [31:0] base, input logic [15:0] lst,
                        input logic [1:0] m, input bit wb, input logic [15:0] rpat,
                        input bit poke);
    int n = 0;
    int k = 0;
    int cyc = 0;
    bit mis, fin, last_hs, hs, rdy;
    logic [31:0] low, exp_wb;
    for (int i = 0; i < 16; i++) n += int'(lst[i]);
    mis = (base[1:0] != 2'b00);
    case (m)
      2'b00: low = base;
      2'b01: low = base + 32'd4;
      2'b10: low = base - 32'(4 * n) + 32'd4;
      default: low = base - 32'(4 * n);
    endcase
    exp_wb = m[1] ? base - 32'(4 * n) : base + 32'(4 * n);
    if (mis) n = 0;
    @(negedge clk);
    start = 1'b1; base_addr = base; reg_list = lst; mode = m; wb_en = wb;
    addr_ready = 1'b0;
    @(negedge clk);
    start = 1'b0; base_addr = ~base; reg_list = ~lst; mode = ~m; wb_en = ~wb;
    fin = 1'b0; last_hs = 1'b0;
    while (!fin && cyc < 100) begin
      if (done) begin
        fin = 1'b1;
        chk(k == n, "R8 beat count", 32'(k), 32'(n));
        if (mis) begin
          chk(cyc == 0, "R10 done timing", 32'(cyc), 32'd0);
          chk(align_err == 1'b1, "R10 align_err", 32'(align_err), 32'd1);
          chk(wb_valid == 1'b0, "R10 wb_valid", 32'(wb_valid), 32'd0);
        end else begin
          chk(align_err == 1'b0, "R10 no error", 32'(align_err), 32'd0);
          if (n == 0) begin
            chk(cyc == 0, "R9 done timing", 32'(cyc), 32'd0);
            chk(wb_addr == base, "R9 wb_addr", wb_addr, base);
          end else begin
            chk(last_hs, "R8 done after final beat", 32'(last_hs), 32'd1);
          end
          chk(wb_valid == wb, "R8 wb_valid", 32'(wb_valid), 32'(wb));
          if (wb) chk(wb_addr == exp_wb, "R8 wb_addr", wb_addr, exp_wb);
        end
      end else if (addr_valid) begin
        if (k >= n) chk(1'b0, "R6 extra beat", 32'(k), 32'(n));
        else begin
          chk(addr_out == low + 32'(4 * k), mode_tag(m), addr_out, low + 32'(4 * k));
          chk(int'(addr_reg) == kth_index(lst, k), "R6 register order",
              32'(addr_reg), 32'(kth_index(lst, k)));
        end
      end else begin
        chk(1'b0, "R7 beat dropped without transfer", 32'(addr_valid), 32'd1);
      end
      if (!fin) begin
        rdy = rpat[cyc % 16];
        hs = addr_valid && rdy;
        addr_ready = rdy;
        if (hs) k++;
        last_hs = hs && (k == n);
        start = poke && (cyc == 1);
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) chk(1'b0, "R8 done never seen", 32'(cyc), 32'd100);
    start = 1'b0; addr_ready = 1'b0;
    @(negedge clk);
    chk(!busy && !addr_valid && !done, "R11 no follow-on operation",
        {29'd0, busy, addr_valid, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished_all) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lists [7];
    logic [15:0] pats [3];
    logic [31:0] bases [3];
    lists = '{16'h0000, 16'h0001, 16'h8000, 16'h0013, 16'hA5A5, 16'hFFFF, 16'h0240};
    pats  = '{16'hFFFF, 16'h5555, 16'h0F0F};
    bases = '{32'h0000_1000, 32'h0000_0020, 32'hFFFF_FFE0};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !addr_valid && !done && !wb_valid && !align_err, "R1 reset outputs",
        {27'd0, busy, addr_valid, done, wb_valid, align_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !addr_valid && !done, "R1 idle after release",
        {29'd0, busy, addr_valid, done}, 32'd0);
    for (int b = 0; b < 3; b++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 7; l++)
          for (int w = 0; w < 2; w++)
            for (int p = 0; p < 3; p++)
              run_op(bases[b], lists[l], 2'(m), w[0], pats[p], p == 1); // R11 poke on p==1
    // R10: misaligned bases
    for (int off = 1; off < 4; off++)
      for (int m = 0; m < 4; m++)
        run_op(32'h0000_1000 + 32'(off), 16'h0013, 2'(m), 1'b1, 16'hFFFF, 1'b0);
    finished_all = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule